// File: doc/BRIEF.md
# Capacitor Charge-Time Ratio ADC Sequencer

This block is the digital half of a ratiometric A/D converter built from one capacitor, a charge switch, a switchable reference source and an analog comparator. On a start request it holds the capacitor discharged while the reference source settles. It then times how long the capacitor takes to charge past the reference level. After a fixed discharge gap it times a second charge up to the unknown input level. Because both times come from the same RC network, the component tolerance cancels when they are divided. The result is `Tin * K / Tref`, where K is a stored scale constant. The multiply runs as a shift-add loop and the divide as a restoring loop.

A calibration request runs the same two timed phases with a known half-scale input (2.5 V on a 5 V supply) applied. It sets the scale constant to `Tref * 128 / Tcal`, so later conversions read in the same units as that known level. Time is counted in ticks of the system clock divided by eight. Each phase has its own overflow limit. A result that cannot be represented saturates to full scale. The result is also driven active-low for a bank of indicators, and its top bit is repeated on a separate pin.

Top module: `ccadc_seq`

## Requirements
- R1: After reset, and again after any mid-conversion reset, busy, done, charge, reference enable, result and over-range are 0, discharge is 1, and the scale constant reads back its reset value (100 by default).
- R2: A start seen while idle raises busy on the next cycle. The discharge and reference-enable outputs then stay high for exactly SETTLE_CYC cycles before the charge switch turns on. Busy stays high through the whole conversion.
- R3: The reference time is the number of whole 8-clock ticks elapsed since the charge switch turned on, taken when the synchronized comparator first reads 1. If 256 ticks elapse first, the phase ends with a reference time of 0.
- R4: The input phase ends on a comparator crossing, with a 9-bit input time. If 512 ticks elapse first, the phase ends with the over-range flag set.
- R5: Charge and discharge are never both high. When a phase ends, the charge switch goes low and the node is driven low. The reference source is on only during settling and the reference phase.
- R6: Exactly GAP_CYC cycles pass between the charge switch turning off after the reference phase and turning on for the input phase.
- R7: A normal conversion returns floor(Tin * K / Tref) when that value is at most 255.
- R8: The result is 255 when the over-range flag is set, when the divisor is 0, or when the quotient exceeds 255.
- R9: A calibration conversion (calibrate input 1 at start) sets K to floor(Tref * 128 / Tin), with the R8 saturation rules and the input time as the divisor. It reports that value as the result. A normal conversion leaves K unchanged.
- R10: The indicator bus equals the bitwise inverse of the result, and the separate top-bit pin equals result bit 7.
- R11: Done is a one-cycle pulse issued when busy falls. A start that arrives while busy is ignored and does not begin a second conversion.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start_i | input | 1 | Start a conversion (sampled while idle) |
| cal_i | input | 1 | 1 = calibration conversion, sampled with start |
| cmp_i | input | 1 | Asynchronous comparator output, 1 = capacitor above threshold |
| dis_o | output | 1 | Drive the capacitor node low |
| ref_en_o | output | 1 | Enable the reference source |
| chg_o | output | 1 | Close the charge switch |
| busy_o | output | 1 | Conversion in progress |
| done_o | output | 1 | One-cycle result strobe |
| result_o | output | 8 | Last result |
| over_o | output | 1 | Last input phase overflowed |
| vcal_o | output | 8 | Current scale constant |
| led_n_o | output | 8 | Active-low copy of the result |
| led_msb_o | output | 1 | Result bit 7 |

## Verification
The hardest conditions to reach from the ports are the two timeout exits and the tick boundary at which a crossing is counted. These depend on when the comparator changes relative to a hidden prescaler. The bench acts as the comparator. It watches for the charge switch to rise and then raises the comparator 8*T+2 cycles later. With the two-flop synchronizer, this lands the sample in the middle of tick T. To force a timeout, it never raises the comparator at all. The calibration constant cannot be seen directly while it affects later results, so the vector table chains calibrations with the normal conversions that depend on them.

// File: rtl/ccadc_pkg.sv
package ccadc_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_SETTLE,
        ST_REF,
        ST_GAP,
        ST_IN,
        ST_CALC
    } seq_st_e;

    typedef enum logic [1:0] {
        AR_IDLE,
        AR_MUL,
        AR_DIV
    } ar_st_e;

endpackage

// File: rtl/ccadc_sync.sv
module ccadc_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_i,
    output logic q_o
);
    logic [STAGES-1:0] sh_d, sh_q;

    generate
        if (STAGES == 1) begin : g_one
            always_comb sh_d = d_i;
        end else begin : g_many
            always_comb sh_d = {sh_q[STAGES-2:0], d_i};
        end
    endgenerate

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sh_q <= '0;
        else        sh_q <= sh_d;
    end

    assign q_o = sh_q[STAGES-1];
endmodule

// File: rtl/ccadc_tick.sv
module ccadc_tick #(
    parameter int DIV = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic en_i,
    output logic tick_o
);
    localparam int PW = (DIV > 1) ? $clog2(DIV) : 1;

    logic [PW-1:0] pre_d, pre_q;

    always_comb begin
        if (!en_i)                         pre_d = '0;
        else if (pre_q == PW'(DIV - 1))    pre_d = '0;
        else                               pre_d = pre_q + PW'(1);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) pre_q <= '0;
        else        pre_q <= pre_d;
    end

    assign tick_o = en_i && (pre_q == PW'(DIV - 1));
endmodule

// File: rtl/ccadc_arith.sv
module ccadc_arith import ccadc_pkg::*; #(
    parameter int A_W = 9,
    parameter int B_W = 8,
    parameter int D_W = 9
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               go_i,
    input  logic [A_W-1:0]     a_i,
    input  logic [B_W-1:0]     b_i,
    input  logic [D_W-1:0]     dvs_i,
    output logic               done_o,
    output logic [A_W+B_W-1:0] quo_o
);
    localparam int P_W  = A_W + B_W;
    localparam int IT_W = $clog2(P_W + 1);

    typedef struct packed {
        ar_st_e          st;
        logic [IT_W-1:0] it;
        logic [P_W-1:0]  mc;
        logic [A_W-1:0]  mp;
        logic [P_W-1:0]  acc;
        logic [D_W-1:0]  dvs;
        logic [D_W-1:0]  rem;
        logic [P_W-1:0]  quo;
        logic            done;
    } ar_t;

    ar_t q, n;
    logic [D_W:0]   trial, diff;
    logic           ge;
    logic [P_W-1:0] acc_add;

    always_comb begin
        n      = q;
        n.done = 1'b0;
        trial  = {q.rem, q.quo[P_W-1]};
        diff   = trial - {1'b0, q.dvs};
        ge     = trial >= {1'b0, q.dvs};
        acc_add = q.mp[0] ? (q.acc + q.mc) : q.acc;
        case (q.st)
            AR_IDLE: begin
                if (go_i) begin
                    n.st  = AR_MUL;
                    n.it  = '0;
                    n.mc  = P_W'(b_i);
                    n.mp  = a_i;
                    n.acc = '0;
                    n.dvs = dvs_i;
                end
            end
            AR_MUL: begin
                n.acc = acc_add;
                n.mc  = {q.mc[P_W-2:0], 1'b0};
                n.mp  = {1'b0, q.mp[A_W-1:1]};
                n.it  = q.it + IT_W'(1);
                if (q.it == IT_W'(A_W - 1)) begin
                    n.st  = AR_DIV;
                    n.it  = '0;
                    n.quo = acc_add;
                    n.rem = '0;
                end
            end
            AR_DIV: begin
                n.rem = ge ? diff[D_W-1:0] : trial[D_W-1:0];
                n.quo = {q.quo[P_W-2:0], ge};
                n.it  = q.it + IT_W'(1);
                if (q.it == IT_W'(P_W - 1)) begin
                    n.st   = AR_IDLE;
                    n.done = 1'b1;
                end
            end
            default: n.st = AR_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q    <= '0;
            q.st <= AR_IDLE;
        end else begin
            q <= n;
        end
    end

    assign done_o = q.done;
    assign quo_o  = q.quo;
endmodule

// File: rtl/ccadc_seq.sv
module ccadc_seq import ccadc_pkg::*; #(
    parameter int RES_W       = 8,
    parameter int PRESC       = 8,
    parameter int SETTLE_CYC  = 32,
    parameter int GAP_CYC     = 24,
    parameter int SYNC_STAGES = 2,
    parameter int VCAL_RST    = 100
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             start_i,
    input  logic             cal_i,
    input  logic             cmp_i,
    output logic             dis_o,
    output logic             ref_en_o,
    output logic             chg_o,
    output logic             busy_o,
    output logic             done_o,
    output logic [RES_W-1:0] result_o,
    output logic             over_o,
    output logic [RES_W-1:0] vcal_o,
    output logic [RES_W-1:0] led_n_o,
    output logic             led_msb_o
);
    localparam int TIN_W    = RES_W + 1;
    localparam int CNT_W    = RES_W + 2;
    localparam int P_W      = TIN_W + RES_W;
    localparam int TREF_LIM = 1 << RES_W;
    localparam int TIN_LIM  = 1 << TIN_W;
    localparam int CAL_K    = 1 << (RES_W - 1);
    localparam int DLY_MAX  = (SETTLE_CYC > GAP_CYC) ? SETTLE_CYC : GAP_CYC;
    localparam int DLY_W    = $clog2(DLY_MAX + 1);

    typedef struct packed {
        seq_st_e          st;
        logic [DLY_W-1:0] dly;
        logic [CNT_W-1:0] cnt;
        logic [RES_W-1:0] tref;
        logic [TIN_W-1:0] tin;
        logic             over;
        logic             cal;
        logic [RES_W-1:0] vcal;
        logic [RES_W-1:0] res;
        logic             done;
        logic             go;
    } seq_t;

    seq_t q, n;

    logic             cmp_s, tick, in_phase;
    logic             ar_done;
    logic [P_W-1:0]   quo;
    logic [TIN_W-1:0] op_a, op_dvs;
    logic [RES_W-1:0] op_b, res_val;
    logic             sat;

    ccadc_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst_n(rst_n), .d_i(cmp_i), .q_o(cmp_s)
    );

    assign in_phase = (q.st == ST_REF) || (q.st == ST_IN);

    ccadc_tick #(.DIV(PRESC)) u_tick (
        .clk(clk), .rst_n(rst_n), .en_i(in_phase), .tick_o(tick)
    );

    assign op_a   = q.cal ? TIN_W'(q.tref) : q.tin;
    assign op_b   = q.cal ? RES_W'(CAL_K) : q.vcal;
    assign op_dvs = q.cal ? q.tin : TIN_W'(q.tref);

    ccadc_arith #(.A_W(TIN_W), .B_W(RES_W), .D_W(TIN_W)) u_arith (
        .clk(clk), .rst_n(rst_n), .go_i(q.go),
        .a_i(op_a), .b_i(op_b), .dvs_i(op_dvs),
        .done_o(ar_done), .quo_o(quo)
    );

    assign sat     = q.over || (op_dvs == '0) || (|quo[P_W-1:RES_W]);
    assign res_val = sat ? '1 : quo[RES_W-1:0];

    always_comb begin
        n      = q;
        n.done = 1'b0;
        n.go   = 1'b0;
        n.cnt  = in_phase ? (q.cnt + {{(CNT_W-1){1'b0}}, tick}) : '0;
        case (q.st)
            ST_IDLE: begin
                n.dly = '0;
                if (start_i) begin
                    n.st   = ST_SETTLE;
                    n.cal  = cal_i;
                    n.over = 1'b0;
                end
            end
            ST_SETTLE: begin
                n.dly = q.dly + DLY_W'(1);
                if (q.dly == DLY_W'(SETTLE_CYC - 1)) n.st = ST_REF;
            end
            ST_REF: begin
                n.dly = '0;
                if (cmp_s) begin
                    n.tref = q.cnt[RES_W-1:0];
                    n.st   = ST_GAP;
                end else if (q.cnt == CNT_W'(TREF_LIM)) begin
                    n.tref = '0;
                    n.st   = ST_GAP;
                end
            end
            ST_GAP: begin
                n.dly = q.dly + DLY_W'(1);
                if (q.dly == DLY_W'(GAP_CYC - 1)) n.st = ST_IN;
            end
            ST_IN: begin
                if (cmp_s) begin
                    n.tin  = q.cnt[TIN_W-1:0];
                    n.over = 1'b0;
                    n.st   = ST_CALC;
                    n.go   = 1'b1;
                end else if (q.cnt == CNT_W'(TIN_LIM)) begin
                    n.tin  = '0;
                    n.over = 1'b1;
                    n.st   = ST_CALC;
                    n.go   = 1'b1;
                end
            end
            ST_CALC: begin
                if (ar_done) begin
                    n.res  = res_val;
                    if (q.cal) n.vcal = res_val;
                    n.done = 1'b1;
                    n.st   = ST_IDLE;
                end
            end
            default: n.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= ST_IDLE;
            q.vcal <= RES_W'(VCAL_RST);
        end else begin
            q <= n;
        end
    end

    assign chg_o     = in_phase;
    assign dis_o     = !in_phase;
    assign ref_en_o  = (q.st == ST_SETTLE) || (q.st == ST_REF);
    assign busy_o    = (q.st != ST_IDLE);
    assign done_o    = q.done;
    assign result_o  = q.res;
    assign over_o    = q.over;
    assign vcal_o    = q.vcal;
    assign led_n_o   = ~q.res;
    assign led_msb_o = q.res[RES_W-1];
endmodule

// File: rtl/ccadc_chk.sv
module ccadc_chk #(
    parameter int RES_W = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic             start_i,
    input logic             busy_o,
    input logic             done_o,
    input logic             chg_o,
    input logic             dis_o,
    input logic             ref_en_o,
    input logic             over_o,
    input logic [RES_W-1:0] result_o
);
    a_r5_chg_excl_dis: assert property (@(posedge clk) disable iff (!rst_n)
        !(chg_o && dis_o));

    a_r5_end_discharges: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(chg_o) |-> dis_o);

    a_r2_start_raises_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (start_i && !busy_o) |=> busy_o);

    a_r11_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> !done_o);

    a_r11_done_when_idle: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> (!busy_o && !chg_o && !ref_en_o));

    a_r8_over_saturates: assert property (@(posedge clk) disable iff (!rst_n)
        (done_o && over_o) |-> (result_o == '1));
endmodule

bind ccadc_seq ccadc_chk #(.RES_W(RES_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .start_i(start_i), .busy_o(busy_o),
    .done_o(done_o), .chg_o(chg_o), .dis_o(dis_o), .ref_en_o(ref_en_o),
    .over_o(over_o), .result_o(result_o)
);

// File: tb/sim_ccadc_seq.sv
module sim_ccadc_seq;
    localparam int S_CYC = 32;
    localparam int G_CYC = 24;
    localparam int KRST  = 100;
    localparam int NOC   = 1000;
    localparam int NV    = 14;

    // {cal, tref_ticks, tin_ticks}; a tick count of NOC means no crossing
    localparam logic [20:0] VEC [NV] = '{
        {1'b0, 10'd100, 10'd100},
        {1'b0, 10'd200, 10'd50},
        {1'b1, 10'd150, 10'd120},
        {1'b0, 10'd160, 10'd300},
        {1'b0, 10'd200, 10'd100},
        {1'b0, 10'd100, 10'(NOC)},
        {1'b0, 10'(NOC), 10'd100},
        {1'b0, 10'd1,   10'd1},
        {1'b0, 10'd255, 10'd300},
        {1'b1, 10'd255, 10'd511},
        {1'b0, 10'd63,  10'd200},
        {1'b1, 10'd10,  10'(NOC)},
        {1'b0, 10'd255, 10'd255},
        {1'b0, 10'd100, 10'd50}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic start_i = 1'b0, cal_i = 1'b0, cmp_i = 1'b0;
    logic dis_o, ref_en_o, chg_o, busy_o, done_o, over_o, led_msb_o;
    logic [7:0] result_o, vcal_o, led_n_o;

    int checks = 0;
    int errors = 0;
    int kmod = KRST;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    ccadc_seq #(.RES_W(8), .PRESC(8), .SETTLE_CYC(S_CYC), .GAP_CYC(G_CYC),
                .SYNC_STAGES(2), .VCAL_RST(KRST)) u0 (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .cal_i(cal_i),
        .cmp_i(cmp_i), .dis_o(dis_o), .ref_en_o(ref_en_o), .chg_o(chg_o),
        .busy_o(busy_o), .done_o(done_o), .result_o(result_o),
        .over_o(over_o), .vcal_o(vcal_o), .led_n_o(led_n_o),
        .led_msb_o(led_msb_o)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("  CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    endtask

    function automatic void model(input bit cal, input int tr, input int ti,
                                  output int res, output bit ovr);
        int trc, tic, num, den, qv;
        bit sat;
        trc = (tr >= 256) ? 0 : tr;
        ovr = (ti >= 512);
        tic = ovr ? 0 : ti;
        if (cal) begin num = trc * 128; den = tic; end
        else     begin num = tic * kmod; den = trc; end
        sat = ovr || (den == 0);
        qv  = sat ? 0 : num / den;
        if (sat || qv > 255) res = 255; else res = qv;
        if (cal) kmod = res;
    endfunction

    task automatic check_idle_reset(input string tag);
        chk(busy_o == 0 && done_o == 0 && chg_o == 0 && ref_en_o == 0,
            {tag, " ctrl idle"}, {busy_o, done_o, chg_o, ref_en_o}, 0);
        chk(dis_o == 1, {tag, " discharge held"}, dis_o, 1);
        chk(result_o == 0 && over_o == 0, {tag, " result clear"}, result_o, 0);
        chk(vcal_o == KRST, {tag, " constant reset"}, vcal_o, KRST);
    endtask

    // One conversion; poke=1 also pulses start during the gap (must be ignored)
    task automatic run_conv(input bit cal, input int tr, input int ti, input bit poke);
        int n, exp_res;
        bit exp_ovr;
        cal_i = cal; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        chk(busy_o == 1, "R2 busy after start", busy_o, 1);
        n = 0;
        while (!chg_o) begin
            chk(dis_o == 1 && ref_en_o == 1, "R2 settle drive", {dis_o, ref_en_o}, 3);
            @(negedge clk); n++;
        end
        chk(n == S_CYC, "R2 settle length", n, S_CYC);
        chk(ref_en_o == 1 && dis_o == 0, "R5 ref phase outputs", {ref_en_o, dis_o}, 2);
        if (tr < 256) begin
            repeat (8 * tr + 2) @(negedge clk);
            cmp_i = 1'b1;
        end
        while (chg_o) @(negedge clk);
        cmp_i = 1'b0;
        chk(dis_o == 1 && ref_en_o == 0, "R5 ref phase end", {dis_o, ref_en_o}, 2);
        n = 0;
        while (!chg_o) begin
            @(negedge clk); n++;
            if (poke && n == 3) start_i = 1'b1;
            if (poke && n == 4) start_i = 1'b0;
        end
        chk(n == G_CYC, "R6 gap length", n, G_CYC);
        chk(ref_en_o == 0 && busy_o == 1, "R5 input phase ref off", {ref_en_o, busy_o}, 1);
        if (ti < 512) begin
            repeat (8 * ti + 2) @(negedge clk);
            cmp_i = 1'b1;
        end
        while (chg_o) @(negedge clk);
        cmp_i = 1'b0;
        chk(dis_o == 1, "R5 input phase end discharge", dis_o, 1);
        while (!done_o) @(negedge clk);
        model(cal, tr, ti, exp_res, exp_ovr);
        if (cal) chk(result_o == exp_res, "R9 calibration result", result_o, exp_res);
        else     chk(result_o == exp_res, "R7/R8 conversion result", result_o, exp_res);
        chk(over_o == exp_ovr, "R4 over-range flag", over_o, exp_ovr);
        chk(vcal_o == kmod, "R9 constant", vcal_o, kmod);
        chk(led_n_o == ~result_o && led_msb_o == result_o[7], "R10 display",
            led_n_o, 8'(~result_o));
        chk(busy_o == 0, "R11 busy low at done", busy_o, 0);
        @(negedge clk);
        chk(done_o == 0, "R11 done one cycle", done_o, 0);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            errors++;
            $display("FAIL watchdog expired actual=1 expected=0");
            summary();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        check_idle_reset("R1");
        chk(led_n_o == 8'hFF && led_msb_o == 0, "R1/R10 display reset", led_n_o, 255);
        rst_n = 1'b1;
        @(negedge clk);
        check_idle_reset("R1 post-release");

        for (int i = 0; i < NV; i++) begin
            run_conv(VEC[i][20], int'(VEC[i][19:10]), int'(VEC[i][9:0]), 1'b0);
            repeat (3) @(negedge clk);
        end

        // R11: a second start during the gap must not launch another conversion
        run_conv(1'b0, 40, 20, 1'b1);
        repeat (6) @(negedge clk);
        chk(busy_o == 0 && chg_o == 0, "R11 start while busy ignored", busy_o, 0);

        // R3: crossing at tick 0 gives Tref 0 -> divide by zero saturates (R8)
        run_conv(1'b0, 0, 10, 1'b0);

        // R1: reset in the middle of a reference phase
        cal_i = 1'b1; start_i = 1'b1;
        @(negedge clk);
        start_i = 1'b0;
        while (!chg_o) @(negedge clk);
        repeat (20) @(negedge clk);
        rst_n = 1'b0;
        @(negedge clk);
        check_idle_reset("R1 mid-run");
        rst_n = 1'b1;
        kmod = KRST;
        @(negedge clk);
        run_conv(1'b0, 100, 50, 1'b0);

        finished = 1'b1;
        summary();
    end
endmodule